// File: doc/BRIEF.md
# SRAM Array Access Sequencer

This block sits between a simple request port and a single-port static memory array of 256 rows by 256 columns, one bit per cell. It turns each read or write request into the timed series of control strobes the array's periphery needs: bitline precharge, a one-hot wordline, a one-hot column select, the write-driver enable with its data bit, and the sense-amplifier enable. For reads it captures the sensed bit and raises a one-cycle valid pulse.

The upper eight address bits choose the wordline and the lower eight choose the column. The lengths of the precharge, bitline-development and write-settle phases are set by three configuration inputs, so the sequence can follow the array's electrical timing. A behavioural cell-array model is included inside the top. It stores the bits, lets a bitline differential develop only after the wordline has been up for a minimum number of cycles, and samples and regenerates the selected column when asked.

Top module: `sram_access_seq`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block enters idle. After that edge `bl_precharge` and `req_ready` are 1, every other strobe is 0, `rd_valid` is 0, and every stored cell reads back 0.
- R2: The wordline that rises is bit `req_addr[15:8]` of `wordline`. The column select that rises is bit `req_addr[7:0]` of `col_select`.
- R3: A read, counted from the cycle after acceptance, gives P cycles of precharge only. It then gives D cycles of wordline only, one sample cycle of wordline plus column select, and one regenerate cycle of column select plus `sense_en`. One final cycle follows with precharge on and `rd_valid` high, and the block then returns to idle.
- R4: `bl_precharge` and any wordline are never active in the same cycle.
- R5: A write gives P cycles of precharge only, then one drive cycle with column select and `wdrv_en` while the wordline is still low. S settle cycles follow with wordline, column select and `wdrv_en`, then one close cycle with the wordline dropped while the driver holds. The block then returns to idle.
- R6: `wdrv_en` and `sense_en` are never active together. While `wdrv_en` is high, `wdrv_bit` equals the accepted write data.
- R7: A read returns the bit most recently written to the same row and column. It is not affected by writes to a neighbouring row or column.
- R8: A request is taken only on a clock edge where both `req_valid` and `req_ready` are 1, and `req_ready` is 1 only in idle. A request held valid while the block is busy does not change the running sequence.
- R9: A configuration count of 0 (P = `cfg_prech_cycles`, D = `cfg_develop_cycles`, S = `cfg_settle_cycles`) acts as 1. The counts must stay stable during an access.
- R10: At most one wordline and at most one column select are high in any cycle.
- R11: `rd_valid` is a single-cycle pulse. It rises only in the cycle after `sense_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Row in [15:8], column in [7:0] |
| req_wdata | input | 1 | Bit to write |
| cfg_prech_cycles | input | 8 | Precharge phase length |
| cfg_develop_cycles | input | 8 | Bitline development phase length |
| cfg_settle_cycles | input | 8 | Write settle phase length |
| bl_precharge | output | 1 | Bitline precharge and equalise |
| wordline | output | 256 | One-hot wordline enables |
| col_select | output | 256 | One-hot column selects |
| wdrv_en | output | 1 | Write-driver enable |
| wdrv_bit | output | 1 | Bit driven by the write driver |
| sense_en | output | 1 | Sense-amplifier regenerate enable |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 1 | Captured read bit |

## Verification
Accesses are tried at the lowest and highest addresses and at a middle address, with neighbouring rows and columns left untouched. Together these separate a swapped or shifted row/column split from a correct decode, and show a write leaking into the next cell. Phase lengths vary from 1 to 4 and include zero. Because the bench compares the strobe pattern in every cycle, an off-by-one count or a clamp error moves a phase edge and is caught. A cell is written 1 and then rewritten 0, which tells a stored value apart from a stuck or default one. A request is held valid across a busy read, and reset is applied in the middle of a write, to confirm that the handshake gates entry and that reset clears both sequence and storage.

// File: rtl/sram_seq_pkg.sv
// Shared types for the SRAM access sequencer.
// Assumes nothing beyond IEEE 1800-2017 packages.
package sram_seq_pkg;

    // Phases of one array access.
    typedef enum logic [3:0] {
        PH_IDLE    = 4'd0,
        PH_PRECH   = 4'd1,
        PH_DEVELOP = 4'd2,
        PH_SAMPLE  = 4'd3,
        PH_REGEN   = 4'd4,
        PH_RDONE   = 4'd5,
        PH_WDRIVE  = 4'd6,
        PH_WSETTLE = 4'd7,
        PH_WCLOSE  = 4'd8
    } phase_t;

endpackage

// File: rtl/line_decoder.sv
// One-hot line decoder: raises bit idx of lines when en is high, else all low.
// Assumes idx is stable while en is high.
module line_decoder #(
    parameter int IDX_W = 8
) (
    input  logic                  en,
    input  logic [IDX_W-1:0]      idx,
    output logic [(1<<IDX_W)-1:0] lines
);
    localparam int NLINES = 1 << IDX_W;

    // Shift a single one into the addressed position.
    always_comb begin
        lines = '0;
        if (en) lines = {{(NLINES-1){1'b0}}, 1'b1} << idx;
    end
endmodule

// File: rtl/phase_sequencer.sv
// Access phase controller: steps each accepted request through the precharge,
// wordline, sample, regenerate (read) or drive, settle, close (write) phases,
// and decodes the strobe levels from the current phase.
// Assumes the cfg counts are held stable during an access; a count of 0 acts as 1.
module phase_sequencer
    import sram_seq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             is_write,
    input  logic [CNT_W-1:0] prech_len,
    input  logic [CNT_W-1:0] dev_len,
    input  logic [CNT_W-1:0] settle_len,
    output logic             idle,
    output logic             pre_on,
    output logic             wl_on,
    output logic             cs_on,
    output logic             wr_on,
    output logic             se_on,
    output logic             done_pulse
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    phase_t           phase;
    logic [CNT_W-1:0] cnt;
    logic             op_wr;
    logic [CNT_W-1:0] eff_pre, eff_dev, eff_set;

    // Clamp zero-length phases to one cycle.
    always_comb begin
        eff_pre = (prech_len  == '0) ? ONE : prech_len;
        eff_dev = (dev_len    == '0) ? ONE : dev_len;
        eff_set = (settle_len == '0) ? ONE : settle_len;
    end

    // Phase register, remaining-cycle counter and latched operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            op_wr <= 1'b0;
        end else begin
            unique case (phase)
                PH_IDLE: if (start) begin
                    phase <= PH_PRECH;
                    cnt   <= eff_pre - ONE;
                    op_wr <= is_write;
                end
                PH_PRECH: begin
                    if (cnt != '0) cnt <= cnt - ONE;
                    else if (op_wr) phase <= PH_WDRIVE;
                    else begin
                        phase <= PH_DEVELOP;
                        cnt   <= eff_dev - ONE;
                    end
                end
                PH_DEVELOP: begin
                    if (cnt != '0) cnt <= cnt - ONE;
                    else phase <= PH_SAMPLE;
                end
                PH_SAMPLE:  phase <= PH_REGEN;
                PH_REGEN:   phase <= PH_RDONE;
                PH_RDONE:   phase <= PH_IDLE;
                PH_WDRIVE: begin
                    phase <= PH_WSETTLE;
                    cnt   <= eff_set - ONE;
                end
                PH_WSETTLE: begin
                    if (cnt != '0) cnt <= cnt - ONE;
                    else phase <= PH_WCLOSE;
                end
                PH_WCLOSE:  phase <= PH_IDLE;
                default:    phase <= PH_IDLE;
            endcase
        end
    end

    // Strobe levels decoded from the phase.
    always_comb begin
        idle       = (phase == PH_IDLE);
        pre_on     = (phase == PH_IDLE) || (phase == PH_PRECH) || (phase == PH_RDONE);
        wl_on      = (phase == PH_DEVELOP) || (phase == PH_SAMPLE) || (phase == PH_WSETTLE);
        cs_on      = (phase == PH_SAMPLE) || (phase == PH_REGEN) || (phase == PH_WDRIVE)
                  || (phase == PH_WSETTLE) || (phase == PH_WCLOSE);
        wr_on      = (phase == PH_WDRIVE) || (phase == PH_WSETTLE) || (phase == PH_WCLOSE);
        se_on      = (phase == PH_REGEN);
        done_pulse = (phase == PH_RDONE);
    end

    // Read and write column paths never run in the same cycle.
    assert_no_wr_sense_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_on && se_on));
    // Sense enable follows a cycle where wordline and column select were both up.
    assert_sense_after_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(se_on) |-> $past(wl_on && cs_on));
    // Read valid follows sense enable and lasts one cycle.
    assert_rd_valid_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);
    assert_rd_valid_after_sense_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_pulse) |-> $past(se_on));
    // Write wordline only rises after the driver is already on.
    assert_driver_before_wordline_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(wl_on) && wr_on) |-> $past(wr_on));
endmodule

// File: rtl/bit_array_model.sv
// Behavioural cell array: stores one bit per row/column, lets a bitline
// differential develop only after the wordline has been up DEV_MIN cycles
// without precharge, samples the selected column and regenerates on sense enable.
// Assumes one-hot (or zero) wordline and column select inputs.
module bit_array_model #(
    parameter int ROW_W   = 8,
    parameter int COL_W   = 8,
    parameter int DEV_MIN = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  precharge,
    input  logic [(1<<ROW_W)-1:0] wl,
    input  logic [(1<<COL_W)-1:0] cs,
    input  logic                  wdrv,
    input  logic                  wbit,
    input  logic                  sense,
    output logic                  sense_out
);
    localparam int NROW  = 1 << ROW_W;
    localparam int NCOL  = 1 << COL_W;
    localparam int DCW   = $clog2(DEV_MIN + 1) + 1;

    logic [NCOL-1:0]  cells [NROW];
    logic [ROW_W-1:0] row_idx;
    logic [COL_W-1:0] col_idx;
    logic             wl_any, cs_any;
    logic [DCW-1:0]   dev_cnt;
    logic             diff_ok, samp, samp_ok;

    // Encode the one-hot lines back into indices.
    always_comb begin
        row_idx = '0;
        col_idx = '0;
        for (int r = 0; r < NROW; r++) if (wl[r]) row_idx = row_idx | ROW_W'(r);
        for (int c = 0; c < NCOL; c++) if (cs[c]) col_idx = col_idx | COL_W'(c);
        wl_any  = |wl;
        cs_any  = |cs;
        diff_ok = (dev_cnt >= DCW'(DEV_MIN));
    end

    // Cell storage: cleared on reset, written through the driver path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NROW; r++) cells[r] <= '0;
        end else if (wl_any && cs_any && wdrv && !precharge) begin
            cells[row_idx][col_idx] <= wbit;
        end
    end

    // Bitline development counter: cycles of open wordline since precharge.
    always_ff @(posedge clk) begin
        if (!rst_n || precharge || !wl_any) dev_cnt <= '0;
        else if (!diff_ok) dev_cnt <= dev_cnt + DCW'(1);
    end

    // Sample stage: capture the developed differential of the selected column.
    always_ff @(posedge clk) begin
        if (!rst_n || precharge) begin
            samp    <= 1'b0;
            samp_ok <= 1'b0;
        end else if (wl_any && cs_any && diff_ok && !wdrv) begin
            samp    <= cells[row_idx][col_idx];
            samp_ok <= 1'b1;
        end
    end

    // Regenerate stage: the latch output is only meaningful while enabled.
    always_comb sense_out = sense & samp;

    // Precharge and an open wordline would fight on the bitlines.
    assert_no_prech_with_wl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(precharge && wl_any));
    // Sense enable only after a valid sample was taken.
    assert_sense_has_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sense |-> samp_ok);
    // Line decoders never raise two lines at once.
    assert_onehot_lines_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wl) && $onehot0(cs));
endmodule

// File: rtl/sram_access_seq.sv
// SRAM array access sequencer top: valid/ready request port, phase sequencer,
// row and column decoders, write-data path, read capture and the behavioural
// array model. Assumes cfg counts stay stable while an access runs.
module sram_access_seq #(
    parameter int ROW_W   = 8,
    parameter int COL_W   = 8,
    parameter int CNT_W   = 8,
    parameter int DEV_MIN = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_write,
    input  logic [ROW_W+COL_W-1:0]   req_addr,
    input  logic                     req_wdata,
    input  logic [CNT_W-1:0]         cfg_prech_cycles,
    input  logic [CNT_W-1:0]         cfg_develop_cycles,
    input  logic [CNT_W-1:0]         cfg_settle_cycles,
    output logic                     bl_precharge,
    output logic [(1<<ROW_W)-1:0]    wordline,
    output logic [(1<<COL_W)-1:0]    col_select,
    output logic                     wdrv_en,
    output logic                     wdrv_bit,
    output logic                     sense_en,
    output logic                     rd_valid,
    output logic                     rd_data
);
    localparam int ADDR_W = ROW_W + COL_W;

    logic              accept;
    logic [ADDR_W-1:0] addr_q;
    logic              wdata_q;
    logic              wl_on, cs_on, sense_bit;

    assign accept = req_valid && req_ready;

    // Hold the request address and data for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= 1'b0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    phase_sequencer #(.CNT_W(CNT_W)) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (accept),
        .is_write   (req_write),
        .prech_len  (cfg_prech_cycles),
        .dev_len    (cfg_develop_cycles),
        .settle_len (cfg_settle_cycles),
        .idle       (req_ready),
        .pre_on     (bl_precharge),
        .wl_on      (wl_on),
        .cs_on      (cs_on),
        .wr_on      (wdrv_en),
        .se_on      (sense_en),
        .done_pulse (rd_valid)
    );

    line_decoder #(.IDX_W(ROW_W)) i_row_dec (
        .en    (wl_on),
        .idx   (addr_q[ADDR_W-1:COL_W]),
        .lines (wordline)
    );

    line_decoder #(.IDX_W(COL_W)) i_col_dec (
        .en    (cs_on),
        .idx   (addr_q[COL_W-1:0]),
        .lines (col_select)
    );

    // Write data only reaches the driver while it is enabled.
    assign wdrv_bit = wdrv_en & wdata_q;

    bit_array_model #(.ROW_W(ROW_W), .COL_W(COL_W), .DEV_MIN(DEV_MIN)) i_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .precharge (bl_precharge),
        .wl        (wordline),
        .cs        (col_select),
        .wdrv      (wdrv_en),
        .wbit      (wdrv_bit),
        .sense     (sense_en),
        .sense_out (sense_bit)
    );

    // Capture the regenerated bit at the end of the sense cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= 1'b0;
        else if (sense_en) rd_data <= sense_bit;
    end

    // Requests are only taken while idle, and idle always has precharge on.
    assert_ready_implies_precharge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> bl_precharge);
    // A held request does not disturb a running access: address stays put.
    assert_addr_stable_when_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !$past(req_ready)) |-> $stable(addr_q));
endmodule

// File: tb/test_sram_access_seq.sv
module test_sram_access_seq;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic         req_write = 1'b0;
    logic [15:0]  req_addr = '0;
    logic         req_wdata = 1'b0;
    logic [7:0]   cfg_p = 8'd1, cfg_d = 8'd1, cfg_s = 8'd1;
    logic         bl_precharge;
    logic [255:0] wordline, col_select;
    logic         wdrv_en, wdrv_bit, sense_en, rd_valid, rd_data;

    int  n_run = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    always #5 clk = ~clk;

    sram_access_seq i_sram_access_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .cfg_prech_cycles(cfg_p), .cfg_develop_cycles(cfg_d), .cfg_settle_cycles(cfg_s),
        .bl_precharge(bl_precharge), .wordline(wordline), .col_select(col_select),
        .wdrv_en(wdrv_en), .wdrv_bit(wdrv_bit), .sense_en(sense_en),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    // Vector: {op[30], addr[29:14], wdata[13], P[12:9], D[8:5], S[4:1], exp[0]}
    localparam logic [30:0] VEC [12] = '{
        {1'b1, 16'h0000, 1'b1, 4'd1, 4'd1, 4'd1, 1'b0},
        {1'b0, 16'h0000, 1'b0, 4'd1, 4'd1, 4'd1, 1'b1},
        {1'b1, 16'hFFFF, 1'b1, 4'd2, 4'd1, 4'd3, 1'b0},
        {1'b0, 16'hFFFF, 1'b0, 4'd3, 4'd2, 4'd1, 1'b1},
        {1'b0, 16'hFFFE, 1'b0, 4'd1, 4'd4, 4'd1, 1'b0},
        {1'b1, 16'h12AB, 1'b1, 4'd1, 4'd1, 4'd2, 1'b0},
        {1'b0, 16'h12AB, 1'b0, 4'd2, 4'd1, 4'd1, 1'b1},
        {1'b0, 16'h13AB, 1'b0, 4'd1, 4'd2, 4'd1, 1'b0},
        {1'b1, 16'h12AB, 1'b0, 4'd1, 4'd1, 4'd1, 1'b0},
        {1'b0, 16'h12AB, 1'b0, 4'd1, 4'd3, 4'd1, 1'b0},
        {1'b1, 16'h8001, 1'b1, 4'd0, 4'd0, 4'd0, 1'b0},
        {1'b0, 16'h8001, 1'b0, 4'd0, 4'd0, 4'd0, 1'b1}
    };

    // Observed strobes {precharge, wl, cs, wdrv, sense, rd_valid, ready}.
    function automatic logic [6:0] obs();
        return {bl_precharge, |wordline, |col_select, wdrv_en, sense_en, rd_valid, req_ready};
    endfunction

    // Expected strobes for cycle i of an access, from R3/R5 (counts already clamped).
    function automatic logic [6:0] exp_strobes(input logic wr, input int i,
                                               input int p, input int d, input int s);
        if (i <= p) return 7'b1000000;
        if (!wr) begin
            if (i <= p + d)     return 7'b0100000;
            if (i == p + d + 1) return 7'b0110000;
            if (i == p + d + 2) return 7'b0010100;
            if (i == p + d + 3) return 7'b1000010;
        end else begin
            if (i == p + 1)     return 7'b0011000;
            if (i <= p + 1 + s) return 7'b0111000;
            if (i == p + s + 2) return 7'b0011000;
        end
        return 7'b1000001;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, expv);
        end
    endtask

    // Run one access starting at a negedge in idle; ends at a negedge in idle.
    task automatic do_access(input logic [30:0] v, input bit hold);
        logic wr = v[30];
        logic [15:0] addr = v[29:14];
        logic wd = v[13];
        int p = (v[12:9] == 0) ? 1 : int'(v[12:9]);
        int d = (v[8:5]  == 0) ? 1 : int'(v[8:5]);
        int s = (v[4:1]  == 0) ? 1 : int'(v[4:1]);
        int n = wr ? p + s + 2 : p + d + 3;
        string sreq = (v[12:9] == 0) ? "R9" : (hold ? "R8" : (wr ? "R5" : "R3"));
        bit seq_ok = 1'b1, idx_ok = 1'b1, wb_ok = 1'b1;
        logic [6:0] bad_a = '0, bad_e = '0;
        logic got = 1'b0;
        logic [255:0] row_hot = 256'(1) << addr[15:8];
        logic [255:0] col_hot = 256'(1) << addr[7:0];
        cfg_p = 8'(v[12:9]); cfg_d = 8'(v[8:5]); cfg_s = 8'(v[4:1]);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        if (!hold) begin
            req_valid = 1'b0; req_addr = ~addr; req_wdata = ~wd;
        end
        for (int i = 1; i <= n + 1; i++) begin
            logic [6:0] e = exp_strobes(wr, i, p, d, s);
            if (obs() !== e && seq_ok) begin
                seq_ok = 1'b0; bad_a = obs(); bad_e = e;
            end
            if (|wordline && wordline !== row_hot) idx_ok = 1'b0;
            if (|col_select && col_select !== col_hot) idx_ok = 1'b0;
            if (wdrv_en && wdrv_bit !== wd) wb_ok = 1'b0;
            if (wdrv_en && sense_en) wb_ok = 1'b0;
            if (rd_valid) got = rd_data;
            if (i == n && hold) begin
                req_valid = 1'b0; req_addr = ~addr;
            end
            if (i <= n) @(negedge clk);
        end
        check(seq_ok, sreq, "strobe sequence", int'(bad_a), int'(bad_e));
        check(idx_ok, "R2", "one-hot line index", int'(idx_ok), 1);
        if (wr) check(wb_ok, "R6", "write bit / no overlap", int'(wb_ok), 1);
        else    check(got === v[0], "R7", "read data", int'(got), int'(v[0]));
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        #2000000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state.
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(obs() === 7'b1000001 && wordline === '0 && col_select === '0 && rd_data === 1'b0,
              "R1", "reset strobes", int'(obs()), 7'h41);
        rst_n = 1'b1;
        @(negedge clk);

        // Main table.
        foreach (VEC[k]) do_access(VEC[k], 1'b0);

        // R8: idle with no request stays idle.
        begin
            bit ok = 1'b1;
            for (int i = 0; i < 5; i++) begin
                if (obs() !== 7'b1000001) ok = 1'b0;
                @(negedge clk);
            end
            check(ok, "R8", "idle without request", int'(obs()), 7'h41);
        end

        // R8: request held valid during a busy read does not disturb it.
        do_access({1'b0, 16'hFFFF, 1'b0, 4'd2, 4'd2, 4'd1, 1'b1}, 1'b1);

        // R1: reset in the middle of a write returns to idle and clears storage.
        cfg_p = 8'd2; cfg_s = 8'd4;
        req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0000; req_wdata = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(obs() === 7'b1000001 && wordline === '0, "R1", "reset mid-write",
              int'(obs()), 7'h41);
        rst_n = 1'b1;
        @(negedge clk);
        do_access({1'b0, 16'hFFFF, 1'b0, 4'd1, 4'd1, 4'd1, 1'b0}, 1'b0);
        do_access({1'b0, 16'h12AB, 1'b0, 4'd1, 4'd1, 4'd1, 1'b0}, 1'b0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule